// File: doc/BRIEF.md
# Transmit Byte Buffer with Hysteresis Ready Flag

This block is the transmit byte store of a serial controller. The CPU, or a DMA engine, writes bytes into a first-in first-out store, and the serializer takes them out from the head. A single ready flag tells the writer when it may supply more data. The flag has two programmable thresholds. It rises once the stored byte count has drained to the lower mark or below. It falls once the count has climbed above the upper mark. While the count lies between the two marks, the flag keeps its previous value, which prevents it from toggling on every byte.

The flag also acts as the gate for writes: a byte offered while the flag is low is discarded. The flag is held low while the transmitter is disabled and is knocked low by an underrun report. Two outputs are derived from it. One is an interrupt request, qualified by an enable bit. The other is a DMA request, which is not qualified. The current byte count is exported so that the surrounding logic can observe it.

Top module: `tx_hyst_buffer`

## Requirements
- R1: With the transmitter enabled and no underrun, the ready flag is 1 after any clock edge at which the new byte count is less than or equal to `low_mark` (0..31).
- R2: With the transmitter enabled, no underrun, and the new count above `low_mark`, the ready flag is 0 after any edge at which the new count is greater than or equal to `high_mark` + 1. When the two marks overlap, the low-mark rule of R1 takes precedence.
- R3: With the transmitter enabled, no underrun, and the new count above `low_mark` and not above `high_mark`, the ready flag keeps its previous value.
- R4: While `tx_enable` is 0, the ready flag is 0 after the next edge, whatever the count.
- R5: An edge at which `tx_underrun` is 1 leaves the ready flag at 0.
- R6: A byte offered on `wr_valid` is stored only if the ready flag was 1 before the edge. Otherwise the byte is dropped and the count does not increase.
- R7: `irq_req` equals the ready flag ANDed with `irq_enable`.
- R8: `dma_req` equals the ready flag and does not depend on `irq_enable`.
- R9: The store holds up to 32 bytes and returns them in write order; `rd_data` shows the oldest byte. The count never exceeds 32. A write while full is ignored, and a pop while empty is ignored.
- R10: An accepted write and an accepted pop at the same edge leave the count unchanged.
- R11: A synchronous reset empties the store (count 0) and clears the ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_enable | input | 1 | Transmitter enable |
| tx_underrun | input | 1 | Underrun report; clears the ready flag |
| low_mark | input | 5 | Count at or below which the flag rises |
| high_mark | input | 5 | Count above which the flag falls |
| irq_enable | input | 1 | Qualifies the interrupt request |
| wr_valid | input | 1 | Offer a byte for storage |
| wr_data | input | 8 | Byte to store |
| rd_pop | input | 1 | Serializer removes the head byte |
| rd_data | output | 8 | Oldest stored byte |
| byte_count | output | 6 | Bytes currently stored (0..32) |
| tx_ready | output | 1 | Hysteresis ready flag |
| irq_req | output | 1 | Ready interrupt request |
| dma_req | output | 1 | Ready DMA request |

## Verification
On every cycle, the assertions check the hysteresis rules of R1 to R3 against the thresholds sampled at the previous edge. They also check the forced-low cases of R4 and R5, the count bound, the dropping of writes while not ready, the unchanged count on a simultaneous write and pop, and the reset state. Only the bench scenarios can show that bytes come out in write order, that the interrupt request follows its enable bit while the DMA request does not, and that full thresholds cycle the flag through a complete fill and drain. The random phase compares every output against a reference model after each edge.

// File: rtl/txhr_pkg.sv
package txhr_pkg;
    parameter int unsigned TXHR_DATA_W = 8;
    parameter int unsigned TXHR_DEPTH  = 32;
    parameter int unsigned TXHR_MARK_W = 5;

    // Decision taken for the ready flag at an edge
    typedef enum logic [1:0] {
        RDY_HOLD   = 2'd0,
        RDY_RAISE  = 2'd1,
        RDY_DROP   = 2'd2,
        RDY_FORCE0 = 2'd3
    } rdy_act_e;
endpackage

// File: rtl/txhr_store.sv
module txhr_store #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam bit POW2 = ((1 << AW) == DEPTH);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0] wptr_inc, rptr_inc;

    generate
        if (POW2) begin : g_wrap_natural
            assign wptr_inc = ptr_q.wptr + 1'b1;
            assign rptr_inc = ptr_q.rptr + 1'b1;
        end else begin : g_wrap_compare
            assign wptr_inc = (ptr_q.wptr == AW'(DEPTH - 1)) ? '0 : ptr_q.wptr + 1'b1;
            assign rptr_inc = (ptr_q.rptr == AW'(DEPTH - 1)) ? '0 : ptr_q.rptr + 1'b1;
        end
    endgenerate

    always_comb begin
        ptr_d = ptr_q;
        if (push) ptr_d.wptr = wptr_inc;
        if (pop)  ptr_d.rptr = rptr_inc;
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[ptr_q.wptr] <= wdata;
    end

    assign rdata = mem[ptr_q.rptr];
endmodule

// File: rtl/txhr_level.sv
module txhr_level
    import txhr_pkg::*;
#(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned MARK_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_enable,
    input  logic              tx_underrun,
    input  logic [MARK_W-1:0] low_mark,
    input  logic [MARK_W-1:0] high_mark,
    input  logic              wr_req,
    input  logic              rd_req,
    output logic              push_ok,
    output logic              pop_ok,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic              ready
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          rdy;
    } lvl_t;

    lvl_t     lvl_d, lvl_q;
    rdy_act_e act;
    logic [CW-1:0] lo_ext, hi_ext;

    assign lo_ext = CW'(low_mark);
    assign hi_ext = CW'(high_mark);

    always_comb begin
        push_ok = wr_req && lvl_q.rdy && (lvl_q.cnt < CW'(DEPTH));
        pop_ok  = rd_req && (lvl_q.cnt != '0);
        lvl_d   = lvl_q;
        case ({push_ok, pop_ok})
            2'b10:   lvl_d.cnt = lvl_q.cnt + 1'b1;
            2'b01:   lvl_d.cnt = lvl_q.cnt - 1'b1;
            default: lvl_d.cnt = lvl_q.cnt;
        endcase
        if (!tx_enable || tx_underrun)  act = RDY_FORCE0;
        else if (lvl_d.cnt <= lo_ext)   act = RDY_RAISE;
        else if (lvl_d.cnt > hi_ext)    act = RDY_DROP;
        else                            act = RDY_HOLD;
        unique case (act)
            RDY_RAISE: lvl_d.rdy = 1'b1;
            RDY_HOLD:  lvl_d.rdy = lvl_q.rdy;
            default:   lvl_d.rdy = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= '0;
        else     lvl_q <= lvl_d;
    end

    assign count = lvl_q.cnt;
    assign ready = lvl_q.rdy;

    // R1
    assert_raise_low_R1: assert property (@(posedge clk) disable iff (rst)
        (!rst && tx_enable && !tx_underrun) ##1 (lvl_q.cnt <= CW'($past(low_mark)))
        |-> lvl_q.rdy);
    // R2
    assert_drop_high_R2: assert property (@(posedge clk) disable iff (rst)
        (!rst && tx_enable && !tx_underrun) ##1
        ((lvl_q.cnt > CW'($past(high_mark))) && (lvl_q.cnt > CW'($past(low_mark))))
        |-> !lvl_q.rdy);
    // R3
    assert_hold_band_R3: assert property (@(posedge clk) disable iff (rst)
        (!rst && tx_enable && !tx_underrun) ##1
        ((lvl_q.cnt > CW'($past(low_mark))) && (lvl_q.cnt <= CW'($past(high_mark))))
        |-> (lvl_q.rdy == $past(lvl_q.rdy)));
    // R4, R5
    assert_forced_low_R4: assert property (@(posedge clk) disable iff (rst)
        (!tx_enable || tx_underrun) |=> !lvl_q.rdy);
    // R6
    assert_drop_write_R6: assert property (@(posedge clk) disable iff (rst)
        (!lvl_q.rdy && !rd_req) |=> $stable(lvl_q.cnt));
    // R9
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        lvl_q.cnt <= CW'(DEPTH));
    // R10
    assert_pair_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_req && rd_req && lvl_q.rdy && (lvl_q.cnt != '0) && (lvl_q.cnt < CW'(DEPTH)))
        |=> $stable(lvl_q.cnt));
    // R11
    assert_reset_state_R11: assert property (@(posedge clk)
        rst |=> ((lvl_q.cnt == '0) && !lvl_q.rdy));
endmodule

// File: rtl/tx_hyst_buffer.sv
module tx_hyst_buffer
    import txhr_pkg::*;
#(
    parameter int unsigned DATA_W = TXHR_DATA_W,
    parameter int unsigned DEPTH  = TXHR_DEPTH,
    parameter int unsigned MARK_W = TXHR_MARK_W,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_enable,
    input  logic              tx_underrun,
    input  logic [MARK_W-1:0] low_mark,
    input  logic [MARK_W-1:0] high_mark,
    input  logic              irq_enable,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic [CW-1:0]     byte_count,
    output logic              tx_ready,
    output logic              irq_req,
    output logic              dma_req
);
    logic push_ok, pop_ok;

    txhr_level #(.DEPTH(DEPTH), .MARK_W(MARK_W)) u_level (
        .clk        (clk),
        .rst        (rst),
        .tx_enable  (tx_enable),
        .tx_underrun(tx_underrun),
        .low_mark   (low_mark),
        .high_mark  (high_mark),
        .wr_req     (wr_valid),
        .rd_req     (rd_pop),
        .push_ok    (push_ok),
        .pop_ok     (pop_ok),
        .count      (byte_count),
        .ready      (tx_ready)
    );

    txhr_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk  (clk),
        .rst  (rst),
        .push (push_ok),
        .pop  (pop_ok),
        .wdata(wr_data),
        .rdata(rd_data)
    );

    assign irq_req = tx_ready & irq_enable;
    assign dma_req = tx_ready;

    // R6: a store never happens without the flag
    assert_push_gated_R6: assert property (@(posedge clk) disable iff (rst)
        push_ok |-> tx_ready);
endmodule

// File: tb/tx_hyst_buffer_test.sv
module tx_hyst_buffer_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_enable = 1'b0, tx_underrun = 1'b0, irq_enable = 1'b0;
    logic [4:0] low_mark = '0, high_mark = '0;
    logic wr_valid = 1'b0, rd_pop = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [5:0] byte_count;
    logic tx_ready, irq_req, dma_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    byte unsigned mq[$];
    bit m_rdy = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_hyst_buffer uut (
        .clk(clk), .rst(rst), .tx_enable(tx_enable), .tx_underrun(tx_underrun),
        .low_mark(low_mark), .high_mark(high_mark), .irq_enable(irq_enable),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_pop(rd_pop),
        .rd_data(rd_data), .byte_count(byte_count), .tx_ready(tx_ready),
        .irq_req(irq_req), .dma_req(dma_req)
    );

    function automatic bit next_ready(int cnt, bit cur, bit en, bit ur, int lo, int hi);
        if (!en || ur) return 0;
        if (cnt <= lo) return 1;
        if (cnt > hi)  return 0;
        return cur;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Update model from inputs present before the edge
    task automatic model_edge();
        bit push, pop;
        if (rst) begin
            mq.delete();
            m_rdy = 0;
            return;
        end
        push = wr_valid && m_rdy && (mq.size() < DEPTH);
        pop  = rd_pop && (mq.size() > 0);
        if (pop)  void'(mq.pop_front());
        if (push) mq.push_back(wr_data);
        m_rdy = next_ready(mq.size(), m_rdy, tx_enable, tx_underrun, low_mark, high_mark);
    endtask

    task automatic step(string tag);
        model_edge();
        @(posedge clk);
        @(negedge clk);
        check(byte_count == 6'(mq.size()), {tag, " R9 count"}, byte_count, mq.size());
        check(tx_ready == m_rdy, {tag, " ready"}, tx_ready, m_rdy);
        check(irq_req == (m_rdy & irq_enable), "R7 irq", irq_req, m_rdy & irq_enable);
        check(dma_req == m_rdy, "R8 dma", dma_req, m_rdy);
        if (mq.size() > 0)
            check(rd_data == mq[0], "R9 order", rd_data, mq[0]);
    endtask

    task automatic drive(bit w, bit p, byte unsigned d);
        wr_valid = w;
        rd_pop   = p;
        wr_data  = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        step("R11 reset");
        step("R11 reset");
        rst = 1'b0;
        low_mark = 5'd4;
        high_mark = 5'd10;
        // R4: disabled, writes dropped, flag low
        drive(1, 0, 8'h11);
        step("R4 disabled");
        check(byte_count == 0, "R6 drop when not ready", byte_count, 0);
        tx_enable = 1'b1;
        drive(0, 0, 0);
        step("R1 enable at empty");
        check(tx_ready == 1, "R1 raise", tx_ready, 1);
        // Fill until flag drops at 11
        for (int i = 0; i < 14; i++) begin
            drive(1, 0, 8'(8'hA0 + i));
            step("R2 fill");
        end
        check(byte_count == 11, "R2 drop at high+1", byte_count, 11);
        check(tx_ready == 0, "R2 flag low", tx_ready, 0);
        // Drain to 5: R3 flag stays low
        for (int i = 0; i < 6; i++) begin
            drive(0, 1, 0);
            step("R3 drain");
        end
        check(tx_ready == 0, "R3 hold low at 5", tx_ready, 0);
        drive(0, 1, 0);
        step("R1 drain");
        check(tx_ready == 1, "R1 raise at 4", tx_ready, 1);
        // R3 hold high in band
        for (int i = 0; i < 5; i++) begin
            drive(1, 0, 8'(8'h50 + i));
            step("R3 refill");
        end
        check(tx_ready == 1 && byte_count == 9, "R3 hold high at 9", tx_ready, 1);
        // R10 simultaneous
        drive(1, 1, 8'h77);
        step("R10 pair");
        check(byte_count == 9, "R10 count kept", byte_count, 9);
        // R7/R8
        irq_enable = 1'b1;
        drive(0, 0, 0);
        step("R7 ie on");
        check(irq_req == 1, "R7 irq asserted", irq_req, 1);
        irq_enable = 1'b0;
        step("R8 ie off");
        check(dma_req == 1 && irq_req == 0, "R8 dma without ie", dma_req, 1);
        // R5 underrun
        tx_underrun = 1'b1;
        step("R5 underrun");
        check(tx_ready == 0, "R5 cleared", tx_ready, 0);
        tx_underrun = 1'b0;
        drive(1, 0, 8'hEE);
        step("R6 write while low");
        check(byte_count == 9, "R6 write dropped", byte_count, 9);
        // Full marks: fill to 32, then pop on empty
        low_mark = 5'd31;
        high_mark = 5'd31;
        for (int i = 0; i < 30; i++) begin
            drive(1, 0, 8'(i));
            step("R9 fill");
        end
        check(byte_count == 32, "R9 full", byte_count, 32);
        check(tx_ready == 0, "R2 low when full", tx_ready, 0);
        for (int i = 0; i < 34; i++) begin
            drive(0, 1, 0);
            step("R9 drain");
        end
        check(byte_count == 0, "R9 pop on empty ignored", byte_count, 0);
        // Random phase
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 64) == 0) begin
                low_mark  = 5'($urandom);
                high_mark = 5'($urandom);
            end
            tx_enable   = ($urandom % 40) != 0;
            tx_underrun = ($urandom % 50) == 0;
            irq_enable  = $urandom % 2;
            rst         = ($urandom % 500) == 0;
            drive(($urandom % 3) != 0, ($urandom % 2) == 0, 8'($urandom));
            step("R3 random");
        end
        rst = 1'b1;
        drive(0, 0, 0);
        step("R11 final reset");
        check(byte_count == 0 && tx_ready == 0, "R11 cleared", byte_count, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule